// File: doc/BRIEF.md
# Selective-Coefficient Eight-Point Cosine Transform Engine

The engine takes one vector of eight signed samples with a three-bit coefficient number each cycle. It returns only that one coefficient of the eight-point 1-D DCT. It does not return the whole transform. A downstream quantiser or a second engine that works along columns can therefore ask for coefficients in any order and at any rate, up to one per cycle. This avoids a transpose buffer between the row pass and the column pass of a 2-D transform on 8x8 blocks.

The datapath has no multipliers.

- **Folding stage.** It combines mirrored samples. An even coefficient needs the four pair sums x[n]+x[7-n]. An odd coefficient needs the four pair differences x[n]-x[7-n].
- **Routing stage.** It places the needed values, with the right sign, on four product lanes.
- **Product lanes.** Each lane multiplies by a fixed cosine constant. The multiplication is done with shifts, additions and subtractions taken from the constant's signed-digit recoding.
- **Accumulator.** It sums the four lanes and rounds the sum to the output width.

The coefficient number travels with the data, so each result carries the number that requested it.

Top module: `sc_dct_core`

## Requirements
- R1: While reset is held low, and after its release, the outputs read `out_vld`=0, `out_idx`=0 and `out_coef`=0 until the first accepted vector arrives.
- R2: A vector accepted with `in_vld`=1 at a rising edge gives exactly one result. The result is shown with `out_vld`=1 after the fourth rising edge that follows. `out_vld` is 0 in every cycle that has no matching accepted vector.
- R3: `out_idx` of each result equals the `in_idx` that was accepted with the vector four edges earlier.
- R4: For an even `in_idx`=k, `out_coef` = round-half-up(sum over n of x[n]·C(k,n) / 256), within 1 LSB. Here x[n] is the signed 12-bit field at `in_x` bits [12n+11:12n]. The constant is C(k,n) = round(256 · g(k)/2 · cos((2n+1)kπ/16)), with g(0)=1/√2 and g(k)=1 otherwise.
- R5: The same formula as R4, with the same 1 LSB bound, holds for every odd `in_idx`.
- R6: A mirror-symmetric input, x[n]=x[7-n] for all n, gives `out_coef`=0 for every odd index.
- R7: A mirror-antisymmetric input, x[n]=-x[7-n] for all n, gives `out_coef`=0 for every even index.
- R8: Vectors presented on consecutive cycles are all accepted, and their results come out on consecutive cycles. Idle cycles in the input stream appear as idle cycles at the output.
- R9: Full-scale inputs do not wrap. All samples at -2048 with index 0 give -5824. All samples at +2047 with index 0 give +5821.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input vector and index are valid this cycle |
| in_idx | input | 3 | Number of the coefficient to compute |
| in_x | input | 96 | Eight signed 12-bit samples; sample n in bits [12n+11:12n] |
| out_vld | output | 1 | Result valid |
| out_idx | output | 3 | Coefficient number belonging to the result |
| out_coef | output | 16 | Signed rounded coefficient |

## Verification
The hardest condition to reach is a negated routing path driven to full scale. That happens when the pair sum feeding a lane is at its most negative value and the route inverts it, as in index 4 with large negative middle samples. Random data almost never reaches it. The stimulus table therefore holds alternating full-scale rows and constant extremes, and every row is streamed against all eight indices back to back. Symmetric and antisymmetric vectors then check the sum/difference split exactly, because the terms that do not belong to the requested index must cancel to zero. Short gaps in the stream test that results line up with the vectors that produced them.

// File: rtl/sc_dct_pkg.sv
package sc_dct_pkg;

   localparam int N_PTS  = 8;
   localparam int N_HALF = N_PTS / 2;
   localparam int IDX_W  = 3;

   // Halved cosine magnitudes scaled by 2^16; rounded to FRAC bits on use.
   localparam int HC16_A = 32138;   // cos(pi/16)/2
   localparam int HC16_B = 27246;   // cos(3pi/16)/2
   localparam int HC16_C = 18205;   // cos(5pi/16)/2
   localparam int HC16_E = 6393;    // cos(7pi/16)/2
   localparam int HC16_Q = 23170;   // 1/(2*sqrt2)
   localparam int HC16_P = 30274;   // cos(pi/8)/2
   localparam int HC16_R = 12540;   // cos(3pi/8)/2

   function automatic int to_frac(input int v16, input int frac);
      return (v16 + (1 << (15 - frac))) >>> (16 - frac);
   endfunction

   // Constant held by product lane `lane` in the even or the odd mode.
   function automatic int lane_const(input int lane, input bit odd, input int frac);
      int v;
      if (odd) begin
         case (lane)
            0:       v = HC16_A;
            1:       v = HC16_B;
            2:       v = HC16_C;
            default: v = HC16_E;
         endcase
      end else begin
         case (lane)
            0, 1:    v = HC16_Q;
            2:       v = HC16_P;
            default: v = HC16_R;
         endcase
      end
      return to_frac(v, frac);
   endfunction

   // Non-adjacent signed-digit recoding: mask of +1 digits or of -1 digits.
   function automatic logic [31:0] sd_mask(input int k, input bit want_neg);
      int          r;
      logic [31:0] pm;
      logic [31:0] nm;
      r  = k;
      pm = '0;
      nm = '0;
      for (int i = 0; i < 32; i++) begin
         if ((r % 2) != 0) begin
            if ((r % 4) == 1) begin
               pm[i] = 1'b1;
               r     = r - 1;
            end else begin
               nm[i] = 1'b1;
               r     = r + 1;
            end
         end
         r = r / 2;
      end
      return want_neg ? nm : pm;
   endfunction

endpackage

// File: rtl/sc_dct_fold.sv
module sc_dct_fold
   import sc_dct_pkg::*;
#(
   parameter int DIN_W = 12,
   localparam int SW   = DIN_W + 1
) (
   input  logic [N_PTS*DIN_W-1:0] x_flat,
   output logic signed [SW-1:0]   psum [N_HALF],
   output logic signed [SW-1:0]   pdif [N_HALF]
);

   for (genvar n = 0; n < N_HALF; n++) begin : g_pair
      logic signed [DIN_W-1:0] lo_s;
      logic signed [DIN_W-1:0] hi_s;
      assign lo_s    = x_flat[n*DIN_W +: DIN_W];
      assign hi_s    = x_flat[(N_PTS-1-n)*DIN_W +: DIN_W];
      assign psum[n] = SW'(lo_s) + SW'(hi_s);
      assign pdif[n] = SW'(lo_s) - SW'(hi_s);
   end

endmodule

// File: rtl/sc_dct_route.sv
module sc_dct_route
   import sc_dct_pkg::*;
#(
   parameter int SW = 13,
   localparam int UW = SW + 2
) (
   input  logic signed [SW-1:0] psum [N_HALF],
   input  logic signed [SW-1:0] pdif [N_HALF],
   input  logic [IDX_W-1:0]     idx,
   output logic signed [UW-1:0] lane_in [N_HALF]
);

   logic signed [UW-1:0] s [N_HALF];
   logic signed [UW-1:0] d [N_HALF];
   logic signed [UW-1:0] outer_s;
   logic signed [UW-1:0] inner_s;
   logic signed [UW-1:0] outer_d;
   logic signed [UW-1:0] inner_d;

   always_comb begin
      for (int n = 0; n < N_HALF; n++) begin
         s[n] = UW'(psum[n]);
         d[n] = UW'(pdif[n]);
      end
   end

   assign outer_s = s[0] + s[3];
   assign inner_s = s[1] + s[2];
   assign outer_d = s[0] - s[3];
   assign inner_d = s[1] - s[2];

   // Lanes 0..3 hold constants Q,Q,P,R (even) or A,B,C,E (odd).
   always_comb begin
      for (int l = 0; l < N_HALF; l++) lane_in[l] = '0;
      case (idx)
         3'd0: begin lane_in[0] = outer_s; lane_in[1] =  inner_s; end
         3'd4: begin lane_in[0] = outer_s; lane_in[1] = -inner_s; end
         3'd2: begin lane_in[2] = outer_d; lane_in[3] =  inner_d; end
         3'd6: begin lane_in[2] = -inner_d; lane_in[3] = outer_d; end
         3'd1: begin
            lane_in[0] =  d[0]; lane_in[1] = d[1]; lane_in[2] =  d[2]; lane_in[3] =  d[3];
         end
         3'd3: begin
            lane_in[0] = -d[2]; lane_in[1] = d[0]; lane_in[2] = -d[3]; lane_in[3] = -d[1];
         end
         3'd5: begin
            lane_in[0] = -d[1]; lane_in[1] = d[3]; lane_in[2] =  d[0]; lane_in[3] =  d[2];
         end
         default: begin
            lane_in[0] = -d[3]; lane_in[1] = d[2]; lane_in[2] = -d[1]; lane_in[3] =  d[0];
         end
      endcase
   end

endmodule

// File: rtl/sc_dct_cmul.sv
module sc_dct_cmul
   import sc_dct_pkg::*;
#(
   parameter int IN_W   = 15,
   parameter int OUT_W  = 25,
   parameter int NDIG   = 10,
   parameter int K      = 1,
   parameter bit RECODE = 1'b1
) (
   input  logic signed [IN_W-1:0]  din,
   output logic signed [OUT_W-1:0] dout
);

   if (K < 0 || K >= (1 << (NDIG - 1))) begin : g_bad_k
      $error("sc_dct_cmul: constant out of digit range");
   end
   if (NDIG > 31 || OUT_W < IN_W + NDIG) begin : g_bad_w
      $error("sc_dct_cmul: product width too small");
   end

   localparam logic [31:0] ADD_M = RECODE ? sd_mask(K, 1'b0) : 32'(K);
   localparam logic [31:0] SUB_M = RECODE ? sd_mask(K, 1'b1) : 32'd0;

   logic signed [OUT_W-1:0] xe;
   logic signed [OUT_W-1:0] part [NDIG+1];

   assign xe      = OUT_W'(din);
   assign part[0] = '0;

   for (genvar i = 0; i < NDIG; i++) begin : g_dig
      if (ADD_M[i]) begin : g_add
         assign part[i+1] = part[i] + (xe <<< i);
      end else if (SUB_M[i]) begin : g_sub
         assign part[i+1] = part[i] - (xe <<< i);
      end else begin : g_skip
         assign part[i+1] = part[i];
      end
   end

   assign dout = part[NDIG];

endmodule

// File: rtl/sc_dct_lane.sv
module sc_dct_lane
   import sc_dct_pkg::*;
#(
   parameter int IN_W   = 15,
   parameter int OUT_W  = 25,
   parameter int NDIG   = 10,
   parameter int K_EVEN = 1,
   parameter int K_ODD  = 1,
   parameter bit RECODE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [IN_W-1:0]  din,
   input  logic                    odd,
   output logic signed [OUT_W-1:0] prod
);

   logic signed [OUT_W-1:0] p_even;
   logic signed [OUT_W-1:0] p_odd;

   sc_dct_cmul #(.IN_W(IN_W), .OUT_W(OUT_W), .NDIG(NDIG), .K(K_EVEN), .RECODE(RECODE))
      u_even (.din(din), .dout(p_even));

   sc_dct_cmul #(.IN_W(IN_W), .OUT_W(OUT_W), .NDIG(NDIG), .K(K_ODD), .RECODE(RECODE))
      u_odd (.din(din), .dout(p_odd));

   always_ff @(posedge clk) begin
      if (!rst_n) prod <= '0;
      else        prod <= odd ? p_odd : p_even;
   end

endmodule

// File: rtl/sc_dct_core.sv
module sc_dct_core
   import sc_dct_pkg::*;
#(
   parameter int DIN_W  = 12,
   parameter int FRAC   = 8,
   parameter int DOUT_W = 16,
   parameter bit RECODE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_vld,
   input  logic [IDX_W-1:0]         in_idx,
   input  logic [N_PTS*DIN_W-1:0]   in_x,
   output logic                     out_vld,
   output logic [IDX_W-1:0]         out_idx,
   output logic signed [DOUT_W-1:0] out_coef
);

   localparam int SW   = DIN_W + 1;
   localparam int UW   = SW + 2;
   localparam int NDIG = FRAC + 2;
   localparam int PW   = UW + NDIG;
   localparam int AW   = PW + 2;

   if (FRAC < 6 || FRAC > 15) begin : g_bad_frac
      $error("sc_dct_core: FRAC must lie in 6..15");
   end
   if (DOUT_W < DIN_W + 2 || AW < DOUT_W + FRAC) begin : g_bad_out
      $error("sc_dct_core: output width inconsistent");
   end

   // stage 1: fold
   logic signed [SW-1:0] f_sum [N_HALF];
   logic signed [SW-1:0] f_dif [N_HALF];
   logic signed [SW-1:0] s1_sum [N_HALF];
   logic signed [SW-1:0] s1_dif [N_HALF];
   logic                 s1_vld;
   logic [IDX_W-1:0]     s1_idx;

   sc_dct_fold #(.DIN_W(DIN_W)) u_fold (.x_flat(in_x), .psum(f_sum), .pdif(f_dif));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_vld <= 1'b0;
         s1_idx <= '0;
         for (int n = 0; n < N_HALF; n++) begin
            s1_sum[n] <= '0;
            s1_dif[n] <= '0;
         end
      end else begin
         s1_vld <= in_vld;
         s1_idx <= in_idx;
         for (int n = 0; n < N_HALF; n++) begin
            s1_sum[n] <= f_sum[n];
            s1_dif[n] <= f_dif[n];
         end
      end
   end

   // stage 2: route
   logic signed [UW-1:0] r_lane [N_HALF];
   logic signed [UW-1:0] s2_lane [N_HALF];
   logic                 s2_vld;
   logic [IDX_W-1:0]     s2_idx;

   sc_dct_route #(.SW(SW)) u_route (
      .psum(s1_sum), .pdif(s1_dif), .idx(s1_idx), .lane_in(r_lane)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s2_vld <= 1'b0;
         s2_idx <= '0;
         for (int l = 0; l < N_HALF; l++) s2_lane[l] <= '0;
      end else begin
         s2_vld <= s1_vld;
         s2_idx <= s1_idx;
         for (int l = 0; l < N_HALF; l++) s2_lane[l] <= r_lane[l];
      end
   end

   // stage 3: constant products
   logic signed [PW-1:0] s3_prod [N_HALF];
   logic                 s3_vld;
   logic [IDX_W-1:0]     s3_idx;

   for (genvar l = 0; l < N_HALF; l++) begin : g_lane
      sc_dct_lane #(
         .IN_W(UW), .OUT_W(PW), .NDIG(NDIG),
         .K_EVEN(lane_const(l, 1'b0, FRAC)), .K_ODD(lane_const(l, 1'b1, FRAC)),
         .RECODE(RECODE)
      ) u_lane (
         .clk(clk), .rst_n(rst_n), .din(s2_lane[l]), .odd(s2_idx[0]), .prod(s3_prod[l])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s3_vld <= 1'b0;
         s3_idx <= '0;
      end else begin
         s3_vld <= s2_vld;
         s3_idx <= s2_idx;
      end
   end

   // stage 4: accumulate and round half up
   logic signed [AW-1:0] acc;
   logic signed [AW-1:0] acc_rnd;

   always_comb begin
      acc = '0;
      for (int l = 0; l < N_HALF; l++) acc = acc + AW'(s3_prod[l]);
      acc_rnd = (acc + (AW'(1) <<< (FRAC - 1))) >>> FRAC;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_idx  <= '0;
         out_coef <= '0;
      end else begin
         out_vld  <= s3_vld;
         out_idx  <= s3_idx;
         out_coef <= acc_rnd[DOUT_W-1:0];
      end
   end

endmodule

// File: rtl/sc_dct_chk.sv
module sc_dct_chk
   import sc_dct_pkg::*;
#(
   parameter int DIN_W  = 12,
   parameter int DOUT_W = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_vld,
   input logic [IDX_W-1:0]         in_idx,
   input logic [N_PTS*DIN_W-1:0]   in_x,
   input logic                     out_vld,
   input logic [IDX_W-1:0]         out_idx,
   input logic signed [DOUT_W-1:0] out_coef
);

   localparam int LAT = 4;

   logic [2:0] since_rst;
   logic       warm;

   always_ff @(posedge clk) begin
      if (!rst_n)                  since_rst <= '0;
      else if (since_rst < 3'(LAT)) since_rst <= since_rst + 3'd1;
   end

   assign warm = (since_rst == 3'(LAT));

   function automatic logic mirror_sym(input logic [N_PTS*DIN_W-1:0] v);
      logic ok;
      ok = 1'b1;
      for (int n = 0; n < N_HALF; n++)
         if (v[n*DIN_W +: DIN_W] != v[(N_PTS-1-n)*DIN_W +: DIN_W]) ok = 1'b0;
      return ok;
   endfunction

   // R1
   p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !warm |-> !out_vld);

   // R2
   p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> (out_vld == $past(in_vld, 4)));

   // R3
   p_index_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_vld) |-> (out_idx == $past(in_idx, 4)));

   // R4
   p_zero_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_vld && ($past(in_x, 4) == '0)) |-> (out_coef == '0));

   // R6
   p_sym_odd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && out_vld && out_idx[0] && mirror_sym($past(in_x, 4))) |-> (out_coef == '0));

endmodule

bind sc_dct_core sc_dct_chk #(.DIN_W(DIN_W), .DOUT_W(DOUT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_idx(in_idx), .in_x(in_x),
   .out_vld(out_vld), .out_idx(out_idx), .out_coef(out_coef)
);

// File: tb/tb_sc_dct_core.sv
`timescale 1ns/1ps
module tb_sc_dct_core;

   localparam int DW    = 12;
   localparam int OW    = 16;
   localparam int NP    = 8;
   localparam int NROW  = 6;
   localparam real PI   = 3.14159265358979323846;

   localparam int TBL [NROW][NP] = '{
      '{0, 250, 500, 750, 1000, 1250, 1500, 1750},
      '{2047, -2048, 2047, -2048, 2047, -2048, 2047, -2048},
      '{2000, 0, 0, 0, 0, 0, 0, 0},
      '{-1234, 567, 89, -1900, 1400, -3, 777, -2048},
      '{-2048, -2048, -2048, -2048, 2047, 2047, -2048, -2048},
      '{13, -7, 2001, -999, 45, 1680, -1111, 300}
   };

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 in_vld = 1'b0;
   logic [2:0]           in_idx = '0;
   logic [NP*DW-1:0]     in_x = '0;
   logic                 out_vld;
   logic [2:0]           out_idx;
   logic signed [OW-1:0] out_coef;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int sent = 0;
   int got = 0;
   bit finished = 1'b0;

   typedef struct { int coef; int idx; int due; } exp_t;
   exp_t  exp_q [$];
   string tag_q [$];

   sc_dct_core dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_idx(in_idx), .in_x(in_x),
      .out_vld(out_vld), .out_idx(out_idx), .out_coef(out_coef)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [NP*DW-1:0] pack_row(input int r);
      logic [NP*DW-1:0] v;
      for (int n = 0; n < NP; n++) v[n*DW +: DW] = DW'(TBL[r][n]);
      return v;
   endfunction

   function automatic logic [NP*DW-1:0] pack8(input int a0, a1, a2, a3, a4, a5, a6, a7);
      return {DW'(a7), DW'(a6), DW'(a5), DW'(a4), DW'(a3), DW'(a2), DW'(a1), DW'(a0)};
   endfunction

   // R4 / R5 formula with constants rounded to 8 fractional bits
   function automatic int ref_coef(input logic [NP*DW-1:0] v, input int k);
      real acc;
      real g;
      acc = 0.0;
      g = (k == 0) ? 1.0 / $sqrt(2.0) : 1.0;
      for (int n = 0; n < NP; n++) begin
         logic signed [DW-1:0] xs;
         int kq;
         xs  = v[n*DW +: DW];
         kq  = $rtoi($floor(256.0 * g * 0.5 * $cos(real'((2*n+1)*k) * PI / 16.0) + 0.5));
         acc = acc + real'(xs) * real'(kq);
      end
      return $rtoi($floor(acc / 256.0 + 0.5));
   endfunction

   task automatic check(input string req, input bit ok, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   task automatic send(input logic [NP*DW-1:0] v, input int k, input int expv, input string tag);
      exp_t e;
      @(negedge clk);
      in_vld = 1'b1;
      in_idx = 3'(k);
      in_x   = v;
      e.coef = expv;
      e.idx  = k;
      e.due  = cyc + 4;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      sent++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_vld = 1'b0;
         in_x   = '0;
      end
   endtask

   // output monitor: timing (R2, R8), index (R3), value (per tag)
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (out_vld) begin
            got++;
            if (exp_q.size() == 0 || exp_q[0].due != cyc) begin
               check("R2", 1'b0, cyc, (exp_q.size() == 0) ? -1 : exp_q[0].due);
            end else begin
               exp_t  e;
               string t;
               int    diff;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check("R3", int'(out_idx) == e.idx, int'(out_idx), e.idx);
               diff = int'(out_coef) - e.coef;
               check(t, diff <= 1 && diff >= -1, int'(out_coef), e.coef);
            end
         end else if (exp_q.size() != 0 && exp_q[0].due == cyc) begin
            check("R2", 1'b0, 0, 1);
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
         end
      end
   end

   initial begin
      #(8ns * 200000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (5) @(negedge clk);
      check("R1", out_vld == 1'b0, int'(out_vld), 0);
      check("R1", out_coef == '0, int'(out_coef), 0);
      check("R1", out_idx == '0, int'(out_idx), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", out_vld == 1'b0, int'(out_vld), 0);

      // table walk: every row against every index, back to back (R4, R5, R8)
      for (int r = 0; r < NROW; r++) begin
         for (int k = 0; k < NP; k++) begin
            send(pack_row(r), k, ref_coef(pack_row(r), k), (k % 2 == 0) ? "R4" : "R5");
         end
      end
      idle(6);

      // R6: mirror-symmetric input, odd indices exactly zero
      for (int k = 1; k < NP; k += 2)
         send(pack8(100, -300, 700, -1500, -1500, 700, -300, 100), k, 0, "R6");
      // R7: antisymmetric input, even indices exactly zero
      for (int k = 0; k < NP; k += 2)
         send(pack8(900, -50, 1200, -2000, 2000, -1200, 50, -900), k, 0, "R7");
      idle(2);

      // R9: full-scale extremes
      send(pack8(-2048, -2048, -2048, -2048, -2048, -2048, -2048, -2048), 0, -5824, "R9");
      send(pack8(2047, 2047, 2047, 2047, 2047, 2047, 2047, 2047), 0, 5821, "R9");
      send(pack8(-2048, -2048, 2047, 2047, 2047, 2047, -2048, -2048), 4,
           ref_coef(pack8(-2048, -2048, 2047, 2047, 2047, 2047, -2048, -2048), 4), "R9");

      // R8: sparse stream with gaps of varying length
      for (int g = 0; g < 4; g++) begin
         send(pack_row(3), g + 3, ref_coef(pack_row(3), g + 3), "R8");
         idle(g + 1);
      end
      idle(8);

      // R2 / R8: every accepted vector produced exactly one result
      check("R8", got == sent, got, sent);
      check("R2", exp_q.size() == 0, exp_q.size(), 0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule